// File: doc/BRIEF.md
# Stack-Machine Data Stack with Registered Top Pair

This block holds the operand stack of a small stack-machine processor. The two topmost values (the top, TOS, and the one beneath it, NOS) sit in their own flip-flops. Every older value sits in a small register array indexed by a wrapping data stack pointer. Each cycle the instruction decoder requests one of three stack actions: hold, push or pop. It may also load a new top value, such as an ALU result. The array is written only on a push, when NOS spills into it. It is read only on a pop, when the entry under NOS refills NOS.

The block also drives the processor's memory write port. A store request takes its address from TOS and its data from NOS. A store is normally issued in the same cycle as a drop. Write enable, address and data are captured into registers at the store edge, so they hold steady for the whole following cycle. They never depend on the stack array's read path. This means a pointer change in the cycle before a store cannot corrupt the values the store presents. The array depth must be a power of two. Overflow and underflow are not reported: the pointer simply wraps.

Top module: `data_stack`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the pointer, TOS, NOS and the write enable to zero.
- R2: Push (`op_i` = 2'b01) is handled as follows. The pointer increments, the old NOS is saved at the new pointer, NOS takes the old TOS, and TOS takes `val_i`.
- R3: Pop (`op_i` = 2'b10) with `tos_ld_i` low is handled as follows. TOS takes the old NOS, NOS takes the array entry at the current pointer, and then the pointer decrements.
- R4: Pop with `tos_ld_i` high behaves as R3, except that TOS takes `val_i`. This gives a two-operand ALU result.
- R5: Hold (`op_i` = 2'b00) and the spare code 2'b11 leave the pointer and NOS unchanged. TOS is replaced by `val_i` only when `tos_ld_i` is high.
- R6: When `store_i` is high at an edge, the next cycle shows `mem_we_o` high, `mem_addr_o` equal to TOS before that edge, and `mem_wdata_o` equal to NOS before that edge. Without a store, `mem_we_o` is low.
- R7: A store fused with a pop presents the pre-drop TOS and NOS. The stack drops exactly as in R3 or R4.
- R8: The write operands of R6 are correct whatever stack action occurred in the cycle before the store.
- R9: The pointer wraps modulo the depth (16 by default). After more pushes than the depth, the newest 16 spilled entries pop back in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Stack action: 00 hold, 01 push, 10 pop, 11 hold |
| tos_ld_i | input | 1 | Load `val_i` into TOS on hold or pop |
| val_i | input | WIDTH | New top value |
| store_i | input | 1 | Issue a memory write of NOS at address TOS |
| tos_o | output | WIDTH | Top of stack |
| nos_o | output | WIDTH | Next on stack |
| dsp_o | output | PTR_W | Data stack pointer |
| mem_we_o | output | 1 | Registered memory write enable |
| mem_addr_o | output | WIDTH | Registered write address |
| mem_wdata_o | output | WIDTH | Registered write data |

## Verification
A long pseudo-random sweep mixes every opcode with random loads and stores, and allows pops only onto slots already written. This separates a wrong spill or refill index from a wrong pointer step, because every stack value differs. Directed stores right after a push or a pop show whether the write operands follow the pointer change. A store fused with a pop checks that the address and data are the pre-drop pair. A run of twenty pushes followed by long pops exercises pointer wrap-around and overwriting of the oldest entries. A mid-run reset leaves the array contents but must clear the registered state.

// File: rtl/ds_pkg.sv
package ds_pkg;
    typedef enum logic [1:0] {
        DS_HOLD = 2'b00,
        DS_PUSH = 2'b01,
        DS_POP  = 2'b10,
        DS_RSVD = 2'b11
    } ds_op_e;
endpackage

// File: rtl/ds_regfile.sv
module ds_regfile #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [PTR_W-1:0] raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] cell_q [DEPTH];

    // one flop row per entry, written only when selected
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (we_i && (waddr_i == PTR_W'(g))) begin
                cell_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/ds_wport.sv
module ds_wport #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             store_i,
    input  logic [WIDTH-1:0] addr_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             we_o,
    output logic [WIDTH-1:0] addr_o,
    output logic [WIDTH-1:0] data_o
);
    typedef struct packed {
        logic             we;
        logic [WIDTH-1:0] addr;
        logic [WIDTH-1:0] data;
    } wr_t;

    wr_t wr_d, wr_q;

    always_comb begin
        wr_d    = wr_q;
        wr_d.we = store_i;
        if (store_i) begin
            wr_d.addr = addr_i;
            wr_d.data = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wr_q <= '0;
        else     wr_q <= wr_d;
    end

    assign we_o   = wr_q.we;
    assign addr_o = wr_q.addr;
    assign data_o = wr_q.data;

    // R6
    store_launch_chk: assert property (@(posedge clk) disable iff (rst)
        store_i |=> (we_o && addr_o == $past(addr_i) && data_o == $past(data_i)));

    // R6
    no_store_chk: assert property (@(posedge clk) disable iff (rst)
        !store_i |=> !we_o);
endmodule

// File: rtl/data_stack.sv
module data_stack
    import ds_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op_i,
    input  logic             tos_ld_i,
    input  logic [WIDTH-1:0] val_i,
    input  logic             store_i,
    output logic [WIDTH-1:0] tos_o,
    output logic [WIDTH-1:0] nos_o,
    output logic [PTR_W-1:0] dsp_o,
    output logic             mem_we_o,
    output logic [WIDTH-1:0] mem_addr_o,
    output logic [WIDTH-1:0] mem_wdata_o
);
    typedef struct packed {
        logic [PTR_W-1:0] dsp;
        logic [WIDTH-1:0] tos;
        logic [WIDTH-1:0] nos;
    } core_t;

    core_t            core_d, core_q;
    ds_op_e           op;
    logic             spill_we;
    logic [PTR_W-1:0] spill_idx;
    logic [WIDTH-1:0] refill_val;

    assign op = ds_op_e'(op_i);

    always_comb begin
        core_d    = core_q;
        spill_we  = 1'b0;
        spill_idx = core_q.dsp + 1'b1;
        unique case (op)
            DS_PUSH: begin
                spill_we   = 1'b1;
                core_d.dsp = spill_idx;
                core_d.nos = core_q.tos;
                core_d.tos = val_i;
            end
            DS_POP: begin
                core_d.dsp = core_q.dsp - 1'b1;
                core_d.nos = refill_val;
                core_d.tos = tos_ld_i ? val_i : core_q.nos;
            end
            default: begin
                if (tos_ld_i) core_d.tos = val_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '0;
        else     core_q <= core_d;
    end

    ds_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_cells (
        .clk     (clk),
        .we_i    (spill_we),
        .waddr_i (spill_idx),
        .wdata_i (core_q.nos),
        .raddr_i (core_q.dsp),
        .rdata_o (refill_val)
    );

    ds_wport #(.WIDTH(WIDTH)) u_wport (
        .clk     (clk),
        .rst     (rst),
        .store_i (store_i),
        .addr_i  (core_q.tos),
        .data_i  (core_q.nos),
        .we_o    (mem_we_o),
        .addr_o  (mem_addr_o),
        .data_o  (mem_wdata_o)
    );

    assign tos_o = core_q.tos;
    assign nos_o = core_q.nos;
    assign dsp_o = core_q.dsp;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dsp_o == '0 && tos_o == '0 && nos_o == '0 && !mem_we_o));

    // R2
    push_move_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 2'b01)
        |-> (tos_o == $past(val_i) && nos_o == $past(tos_o) && dsp_o == $past(dsp_o) + 1'b1));

    // R3
    pop_move_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 2'b10 && !$past(tos_ld_i))
        |-> (tos_o == $past(nos_o) && dsp_o == $past(dsp_o) - 1'b1));

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_i) == 2'b00 || $past(op_i) == 2'b11))
        |-> ($stable(dsp_o) && $stable(nos_o)));

    // R7
    fused_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(store_i) && $past(op_i) == 2'b10 && !$past(tos_ld_i))
        |-> (mem_wdata_o == tos_o && mem_addr_o == $past(tos_o)));

    // R8
    prior_move_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(store_i) && $past(op_i, 2) != 2'b00)
        |-> (mem_addr_o == $past(tos_o) && mem_wdata_o == $past(nos_o)));
endmodule

// File: tb/tb_data_stack.sv
module tb_data_stack;
    localparam int W  = 16;
    localparam int D  = 16;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    op = 2'b00;
    logic          ld = 1'b0;
    logic [W-1:0]  val = '0;
    logic          st = 1'b0;
    logic [W-1:0]  tos, nos, addr, wdata;
    logic [PW-1:0] dsp;
    logic          we;

    data_stack #(.WIDTH(W), .DEPTH(D)) dut (
        .clk(clk), .rst(rst), .op_i(op), .tos_ld_i(ld), .val_i(val), .store_i(st),
        .tos_o(tos), .nos_o(nos), .dsp_o(dsp),
        .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata)
    );

    always #10 clk = ~clk;

    logic [W-1:0]  m_tos, m_nos, e_addr, e_data;
    logic [PW-1:0] m_ptr;
    logic [W-1:0]  m_arr [D];
    logic          m_vld [D];
    logic          e_we;
    logic          done = 1'b0;
    logic [31:0]   lfsr = 32'hACE1_2468;
    int            n_chk = 0;
    int            n_fail = 0;

    task automatic check(input string req);
        n_chk++;
        if (tos !== m_tos || nos !== m_nos || dsp !== m_ptr || we !== e_we ||
            (e_we && (addr !== e_addr || wdata !== e_data))) begin
            n_fail++;
            $display("FAIL %s: tos=%h nos=%h dsp=%0d we=%b addr=%h data=%h | expected tos=%h nos=%h dsp=%0d we=%b addr=%h data=%h",
                     req, tos, nos, dsp, we, addr, wdata, m_tos, m_nos, m_ptr, e_we, e_addr, e_data);
        end
    endtask

    task automatic step(input logic [1:0] o, input logic l, input logic [W-1:0] v,
                        input logic s, input string req);
        logic [PW-1:0] p;
        op = o; ld = l; val = v; st = s;
        e_we = s;
        if (s) begin
            e_addr = m_tos;
            e_data = m_nos;
        end
        case (o)
            2'b01: begin
                p = m_ptr + 1'b1;
                m_arr[p] = m_nos;
                m_vld[p] = 1'b1;
                m_nos = m_tos;
                m_tos = v;
                m_ptr = p;
            end
            2'b10: begin
                m_tos = l ? v : m_nos;
                m_nos = m_arr[m_ptr];
                m_ptr = m_ptr - 1'b1;
            end
            default: if (l) m_tos = v;
        endcase
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    task automatic do_reset();
        rst = 1'b1; op = 2'b00; ld = 1'b0; st = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_tos = '0; m_nos = '0; m_ptr = '0; e_we = 1'b0;
        check("R1");
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) m_vld[i] = 1'b0;
        @(negedge clk);
        do_reset();

        // R5: hold, spare code, loads on hold
        step(2'b00, 1'b0, 16'hDEAD, 1'b0, "R5");
        step(2'b11, 1'b1, 16'h1234, 1'b0, "R5");
        step(2'b00, 1'b1, 16'h5678, 1'b0, "R5");
        step(2'b11, 1'b0, 16'hFFFF, 1'b0, "R5");

        // R9: more pushes than the depth, then long pops
        for (int k = 0; k < 20; k++) step(2'b01, 1'b0, W'(16'h0100 + k), 1'b0, "R9");
        for (int k = 0; k < 18; k++) step(2'b10, 1'b0, 16'h0000, 1'b0, "R9");

        // R8: stores right after pointer movement
        step(2'b01, 1'b0, 16'hA5A5, 1'b0, "R2");
        step(2'b10, 1'b0, 16'h0000, 1'b1, "R8");
        step(2'b10, 1'b0, 16'h0000, 1'b0, "R3");
        step(2'b00, 1'b0, 16'h0000, 1'b1, "R8");
        step(2'b01, 1'b0, 16'h0F0F, 1'b1, "R6");
        step(2'b10, 1'b1, 16'h7777, 1'b1, "R7");
        step(2'b10, 1'b1, 16'h3C3C, 1'b0, "R4");

        // R2 R3 R4 R6 R7 R8: pseudo-random sweep with a mid-run reset
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] o;
            logic       l, s;
            string      req;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (i == 2000) do_reset();
            o = lfsr[1:0];
            if (o == 2'b10 && !m_vld[m_ptr]) o = 2'b01;
            l = lfsr[2];
            s = lfsr[3] & lfsr[4];
            if (s && (op == 2'b01 || op == 2'b10)) req = "R8";
            else if (s && o == 2'b10)             req = "R7";
            else if (s)                           req = "R6";
            else if (o == 2'b01)                  req = "R2";
            else if (o == 2'b10 && l)             req = "R4";
            else if (o == 2'b10)                  req = "R3";
            else                                  req = "R5";
            step(o, l, lfsr[31:16], s, req);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule